// File: doc/BRIEF.md
# Translation Controller with Accessed/Dirty Maintenance

The controller serves one virtual-to-physical translation at a time. A request carries a virtual address, an access kind, the privilege, and the two permission relaxation flags: make-executable-readable and supervisor-may-touch-user. It also has the address-space id, the root table page number, a paged/bare mode select and a platform switch that allows hardware to set the accessed and dirty flags. In bare mode the address passes through. In paged mode the controller asks the TLB. On a miss it starts an external table walker. In both cases it decides whether the page table entry needs its accessed or dirty flag set.

When an entry needs a flag update and the platform switch is off, the request faults. When the switch is on, the updated entry is first written back to memory at its table address. Only after that write is acknowledged without error is the TLB entry rewritten (hit path) or filled (miss path). The result is a one-cycle response carrying either a physical address or a fault code.

Fault codes on `rsp_fault_o`: 0 none, 1 access fault, 3 permission denied, 5 flag update not allowed. Codes 1 to 4 from the walker are passed through. Entry attribute bits in the low byte: bit 0 valid, 1 read, 2 write, 3 execute, 4 user, 5 global, 6 accessed, 7 dirty. Access kind: 0 load, 1 store, 2 fetch.

Top module: `xlat_ctrl`

## Requirements
- R1: With `paged_i` low, an accepted request responds in the next cycle with ok set and `rsp_paddr_o` equal to the zero-extended virtual address. No TLB lookup, walk or memory write takes place.
- R2: On a TLB hit the stored attributes are checked again, and a failed check answers fault 3. The rules are: user mode needs bit 4 set; supervisor mode with bit 4 set denies fetches and allows data only with the user-access flag; a load needs bit 1, or bit 3 with the make-executable-readable flag; a store needs bit 2; a fetch needs bit 3.
- R3: A hit that passes the check and needs no flag update answers with the entry base ORed with the virtual address masked by the entry selection mask.
- R4: A flag update is needed when bit 6 is clear on any access, or when bit 7 is clear on a store. The updated entry sets bit 6, and also bit 7 on a store.
- R5: When an update is needed and `ad_upd_en_i` is low, the answer is fault 5, on a hit and on a walk success alike, with no memory write and no TLB change.
- R6: On a hit needing an update with updates enabled, the updated entry is written to the entry's stored table address. After an error-free acknowledge, the TLB entry at the hit index is rewritten with it and the hit address is returned. A write error answers fault 1 with no rewrite.
- R7: On a miss, one walk is started, and a walker failure code is returned unchanged.
- R8: A walk success with no update needed fills the TLB with the walker's result and returns the walker's physical address.
- R9: A walk success needing an update writes the updated entry to the walker-reported table address first. A write error answers fault 1 without a fill. Otherwise the fill carries the updated entry and the walker's address is returned.
- R10: Only one request is outstanding. Ready is low from acceptance until the response, and the response is a single-cycle pulse.
- R11: A memory write request keeps its address and data stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, can accept |
| req_vaddr_i | input | VA_W | Virtual address |
| req_acc_i | input | 2 | Access kind (0 load, 1 store, 2 fetch) |
| req_priv_s_i | input | 1 | 1 supervisor, 0 user |
| req_mxr_i | input | 1 | Executable pages readable |
| req_sum_i | input | 1 | Supervisor may access user pages |
| asid_i | input | ASID_W | Address-space id |
| root_ppn_i | input | PPN_W | Root table page number |
| paged_i | input | 1 | 1 paged, 0 bare |
| ad_upd_en_i | input | 1 | Hardware flag update allowed |
| tlb_lkp_o | output | 1 | TLB lookup strobe |
| tlb_lkp_vaddr_o | output | VA_W | Lookup address |
| tlb_lkp_asid_o | output | ASID_W | Lookup address-space id |
| tlb_hit_i | input | 1 | Lookup hit (same cycle) |
| tlb_hit_idx_i | input | IDX_W | Index of hit entry |
| tlb_pte_i | input | PTE_W | Stored entry |
| tlb_pbase_i | input | PA_W | Stored physical base |
| tlb_sel_mask_i | input | VA_W | Stored selection mask |
| tlb_pte_addr_i | input | PA_W | Stored table address of entry |
| tlb_fill_o | output | 1 | Fill new entry |
| tlb_wr_o | output | 1 | Rewrite entry at index |
| tlb_wr_idx_o | output | IDX_W | Rewrite index |
| tlb_w_vaddr_o | output | VA_W | Fill virtual address |
| tlb_w_asid_o | output | ASID_W | Fill address-space id |
| tlb_w_paddr_o | output | PA_W | Fill physical address |
| tlb_w_pte_o | output | PTE_W | Entry to store |
| tlb_w_pte_addr_o | output | PA_W | Fill table address |
| tlb_w_lvl_o | output | LVL_W | Fill page level |
| tlb_w_glb_o | output | 1 | Fill global flag |
| walk_start_o | output | 1 | Walk start pulse |
| walk_vaddr_o | output | VA_W | Walk address |
| walk_root_o | output | PPN_W | Walk root |
| walk_acc_o | output | 2 | Walk access kind |
| walk_priv_s_o | output | 1 | Walk privilege |
| walk_mxr_o | output | 1 | Walk executable-readable flag |
| walk_sum_o | output | 1 | Walk user-access flag |
| walk_done_i | input | 1 | Walk finished |
| walk_ok_i | input | 1 | Walk succeeded |
| walk_err_i | input | 3 | Walk failure code |
| walk_paddr_i | input | PA_W | Walk physical address |
| walk_pte_i | input | PTE_W | Leaf entry |
| walk_pte_addr_i | input | PA_W | Leaf table address |
| walk_lvl_i | input | LVL_W | Leaf level |
| walk_glb_i | input | 1 | Leaf global |
| mw_valid_o | output | 1 | Entry write-back request |
| mw_addr_o | output | PA_W | Write-back address |
| mw_data_o | output | PTE_W | Write-back data |
| mw_ack_i | input | 1 | Write-back done |
| mw_err_i | input | 1 | Write-back error (with ack) |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_ok_o | output | 1 | Translation succeeded |
| rsp_fault_o | output | 3 | Fault code |
| rsp_paddr_o | output | PA_W | Physical address |

## Verification
Directed requests each take one branch: bare pass-through, hit with denied permission, plain hit, hit with a flag update (enabled, disabled, write error), walker failure, plain walk, and walk with a flag update. These separate the ordering of write-back before TLB update from the fault selection. Random requests then mix attribute bytes, privilege, the two relaxation flags, page levels, walker results and memory errors. That pattern checks the permission rules and the accessed/dirty decision against every access kind, and the masked address merge at every page size.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int FLT_W = 3;
  localparam logic [FLT_W-1:0] FLT_NONE   = 3'd0;
  localparam logic [FLT_W-1:0] FLT_ACCESS = 3'd1;
  localparam logic [FLT_W-1:0] FLT_NOPERM = 3'd3;
  localparam logic [FLT_W-1:0] FLT_ADUPD  = 3'd5;

  // attribute bit positions in the entry
  localparam int PB_R = 1;
  localparam int PB_W = 2;
  localparam int PB_X = 3;
  localparam int PB_U = 4;
  localparam int PB_A = 6;
  localparam int PB_D = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WALK, ST_HIT_WR, ST_MISS_WR
  } st_e;
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  logic [7:0] attr_i,
  input  logic [1:0] acc_i,
  input  logic       priv_s_i,
  input  logic       mxr_i,
  input  logic       sum_i,
  output logic       allow_o
);
  logic acc_ok, priv_ok;

  always_comb begin
    case (acc_i)
      ACC_LOAD:  acc_ok = attr_i[PB_R] | (attr_i[PB_X] & mxr_i);
      ACC_STORE: acc_ok = attr_i[PB_W];
      ACC_FETCH: acc_ok = attr_i[PB_X];
      default:   acc_ok = 1'b0;
    endcase
    if (priv_s_i) priv_ok = !attr_i[PB_U] | ((acc_i != ACC_FETCH) & sum_i);
    else          priv_ok = attr_i[PB_U];
    allow_o = acc_ok & priv_ok;
  end
endmodule

// File: rtl/xlat_ad.sv
module xlat_ad
  import xlat_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             store_i,
  output logic             need_o,
  output logic [PTE_W-1:0] pte_o
);
  always_comb begin
    need_o = !pte_i[PB_A] | (store_i & !pte_i[PB_D]);
    pte_o  = pte_i;
    pte_o[PB_A] = 1'b1;
    if (store_i) pte_o[PB_D] = 1'b1;
  end
endmodule

// File: rtl/xlat_merge.sv
module xlat_merge #(
  parameter int VA_W = 39,
  parameter int PA_W = 56
) (
  input  logic [PA_W-1:0] base_i,
  input  logic [VA_W-1:0] mask_i,
  input  logic [VA_W-1:0] va_i,
  output logic [PA_W-1:0] pa_o
);
  localparam int PAD_W = PA_W - VA_W;

  assign pa_o = base_i | {{PAD_W{1'b0}}, va_i & mask_i};
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int VA_W   = 39,
  parameter int PA_W   = 56,
  parameter int ASID_W = 16,
  parameter int PPN_W  = 44,
  parameter int PTE_W  = 64,
  parameter int LVL_W  = 2,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_acc_i,
  input  logic              req_priv_s_i,
  input  logic              req_mxr_i,
  input  logic              req_sum_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [PPN_W-1:0]  root_ppn_i,
  input  logic              paged_i,
  input  logic              ad_upd_en_i,
  output logic              tlb_lkp_o,
  output logic [VA_W-1:0]   tlb_lkp_vaddr_o,
  output logic [ASID_W-1:0] tlb_lkp_asid_o,
  input  logic              tlb_hit_i,
  input  logic [IDX_W-1:0]  tlb_hit_idx_i,
  input  logic [PTE_W-1:0]  tlb_pte_i,
  input  logic [PA_W-1:0]   tlb_pbase_i,
  input  logic [VA_W-1:0]   tlb_sel_mask_i,
  input  logic [PA_W-1:0]   tlb_pte_addr_i,
  output logic              tlb_fill_o,
  output logic              tlb_wr_o,
  output logic [IDX_W-1:0]  tlb_wr_idx_o,
  output logic [VA_W-1:0]   tlb_w_vaddr_o,
  output logic [ASID_W-1:0] tlb_w_asid_o,
  output logic [PA_W-1:0]   tlb_w_paddr_o,
  output logic [PTE_W-1:0]  tlb_w_pte_o,
  output logic [PA_W-1:0]   tlb_w_pte_addr_o,
  output logic [LVL_W-1:0]  tlb_w_lvl_o,
  output logic              tlb_w_glb_o,
  output logic              walk_start_o,
  output logic [VA_W-1:0]   walk_vaddr_o,
  output logic [PPN_W-1:0]  walk_root_o,
  output logic [1:0]        walk_acc_o,
  output logic              walk_priv_s_o,
  output logic              walk_mxr_o,
  output logic              walk_sum_o,
  input  logic              walk_done_i,
  input  logic              walk_ok_i,
  input  logic [2:0]        walk_err_i,
  input  logic [PA_W-1:0]   walk_paddr_i,
  input  logic [PTE_W-1:0]  walk_pte_i,
  input  logic [PA_W-1:0]   walk_pte_addr_i,
  input  logic [LVL_W-1:0]  walk_lvl_i,
  input  logic              walk_glb_i,
  output logic              mw_valid_o,
  output logic [PA_W-1:0]   mw_addr_o,
  output logic [PTE_W-1:0]  mw_data_o,
  input  logic              mw_ack_i,
  input  logic              mw_err_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic [2:0]        rsp_fault_o,
  output logic [PA_W-1:0]   rsp_paddr_o
);
  localparam int PAD_W = PA_W - VA_W;

  st_e               state_q;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q;
  logic              priv_q, mxr_q, sum_q, en_q;
  logic [ASID_W-1:0] asid_q;
  logic [PPN_W-1:0]  root_q;
  logic [PTE_W-1:0]  pte_q;
  logic [PA_W-1:0]   pte_addr_q, paddr_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              glb_q;
  logic [IDX_W-1:0]  idx_q;
  logic              rsp_valid_q, rsp_ok_q, fill_q, wr_q;
  logic [2:0]        flt_q;

  logic              store_q;
  logic              hit_allow, hit_need, walk_need;
  logic [PTE_W-1:0]  hit_pte_upd, walk_pte_upd;
  logic [PA_W-1:0]   hit_paddr;

  assign store_q = (acc_q == ACC_STORE);

  xlat_perm u_perm (
    .attr_i   (tlb_pte_i[7:0]),
    .acc_i    (acc_q),
    .priv_s_i (priv_q),
    .mxr_i    (mxr_q),
    .sum_i    (sum_q),
    .allow_o  (hit_allow)
  );

  xlat_ad #(.PTE_W(PTE_W)) u_ad_hit (
    .pte_i   (tlb_pte_i),
    .store_i (store_q),
    .need_o  (hit_need),
    .pte_o   (hit_pte_upd)
  );

  xlat_ad #(.PTE_W(PTE_W)) u_ad_walk (
    .pte_i   (walk_pte_i),
    .store_i (store_q),
    .need_o  (walk_need),
    .pte_o   (walk_pte_upd)
  );

  xlat_merge #(.VA_W(VA_W), .PA_W(PA_W)) u_merge (
    .base_i (tlb_pbase_i),
    .mask_i (tlb_sel_mask_i),
    .va_i   (va_q),
    .pa_o   (hit_paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      acc_q       <= ACC_LOAD;
      priv_q      <= 1'b0;
      mxr_q       <= 1'b0;
      sum_q       <= 1'b0;
      en_q        <= 1'b0;
      asid_q      <= '0;
      root_q      <= '0;
      pte_q       <= '0;
      pte_addr_q  <= '0;
      paddr_q     <= '0;
      lvl_q       <= '0;
      glb_q       <= 1'b0;
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_ok_q    <= 1'b0;
      flt_q       <= FLT_NONE;
      fill_q      <= 1'b0;
      wr_q        <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      fill_q      <= 1'b0;
      wr_q        <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q   <= req_vaddr_i;
            acc_q  <= req_acc_i;
            priv_q <= req_priv_s_i;
            mxr_q  <= req_mxr_i;
            sum_q  <= req_sum_i;
            asid_q <= asid_i;
            root_q <= root_ppn_i;
            en_q   <= ad_upd_en_i;
            if (!paged_i) begin
              paddr_q     <= {{PAD_W{1'b0}}, req_vaddr_i};
              rsp_valid_q <= 1'b1;
              rsp_ok_q    <= 1'b1;
              flt_q       <= FLT_NONE;
            end else begin
              state_q <= ST_LOOKUP;
            end
          end
        end
        ST_LOOKUP: begin
          if (tlb_hit_i) begin
            idx_q      <= tlb_hit_idx_i;
            pte_addr_q <= tlb_pte_addr_i;
            pte_q      <= hit_pte_upd;
            paddr_q    <= hit_paddr;
            if (!hit_allow) begin
              state_q <= ST_IDLE; rsp_valid_q <= 1'b1; rsp_ok_q <= 1'b0; flt_q <= FLT_NOPERM;
            end else if (hit_need && !en_q) begin
              state_q <= ST_IDLE; rsp_valid_q <= 1'b1; rsp_ok_q <= 1'b0; flt_q <= FLT_ADUPD;
            end else if (hit_need) begin
              state_q <= ST_HIT_WR;
            end else begin
              state_q <= ST_IDLE; rsp_valid_q <= 1'b1; rsp_ok_q <= 1'b1; flt_q <= FLT_NONE;
            end
          end else begin
            state_q <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (walk_done_i) begin
            paddr_q    <= walk_paddr_i;
            pte_addr_q <= walk_pte_addr_i;
            lvl_q      <= walk_lvl_i;
            glb_q      <= walk_glb_i;
            pte_q      <= walk_need ? walk_pte_upd : walk_pte_i;
            if (!walk_ok_i) begin
              state_q <= ST_IDLE; rsp_valid_q <= 1'b1; rsp_ok_q <= 1'b0; flt_q <= walk_err_i;
            end else if (walk_need && !en_q) begin
              state_q <= ST_IDLE; rsp_valid_q <= 1'b1; rsp_ok_q <= 1'b0; flt_q <= FLT_ADUPD;
            end else if (walk_need) begin
              state_q <= ST_MISS_WR;
            end else begin
              state_q <= ST_IDLE; rsp_valid_q <= 1'b1; rsp_ok_q <= 1'b1; flt_q <= FLT_NONE;
              fill_q  <= 1'b1;
            end
          end
        end
        ST_HIT_WR, ST_MISS_WR: begin
          if (mw_ack_i) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_ok_q    <= !mw_err_i;
            flt_q       <= mw_err_i ? FLT_ACCESS : FLT_NONE;
            // TLB is touched only after a clean write-back
            if (state_q == ST_HIT_WR) wr_q   <= !mw_err_i;
            else                      fill_q <= !mw_err_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign tlb_lkp_o        = (state_q == ST_LOOKUP);
  assign tlb_lkp_vaddr_o  = va_q;
  assign tlb_lkp_asid_o   = asid_q;

  assign tlb_fill_o       = fill_q;
  assign tlb_wr_o         = wr_q;
  assign tlb_wr_idx_o     = idx_q;
  assign tlb_w_vaddr_o    = va_q;
  assign tlb_w_asid_o     = asid_q;
  assign tlb_w_paddr_o    = paddr_q;
  assign tlb_w_pte_o      = pte_q;
  assign tlb_w_pte_addr_o = pte_addr_q;
  assign tlb_w_lvl_o      = lvl_q;
  assign tlb_w_glb_o      = glb_q;

  assign walk_start_o     = (state_q == ST_LOOKUP) && !tlb_hit_i;
  assign walk_vaddr_o     = va_q;
  assign walk_root_o      = root_q;
  assign walk_acc_o       = acc_q;
  assign walk_priv_s_o    = priv_q;
  assign walk_mxr_o       = mxr_q;
  assign walk_sum_o       = sum_q;

  assign mw_valid_o       = (state_q == ST_HIT_WR) || (state_q == ST_MISS_WR);
  assign mw_addr_o        = pte_addr_q;
  assign mw_data_o        = pte_q;

  assign rsp_valid_o      = rsp_valid_q;
  assign rsp_ok_o         = rsp_ok_q;
  assign rsp_fault_o      = flt_q;
  assign rsp_paddr_o      = paddr_q;
endmodule

// File: rtl/xlat_ctrl_chk.sv
module xlat_ctrl_chk
  import xlat_pkg::*;
#(
  parameter int PA_W  = 56,
  parameter int PTE_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             walk_start_o,
  input logic             mw_valid_o,
  input logic             mw_ack_i,
  input logic [PA_W-1:0]  mw_addr_o,
  input logic [PTE_W-1:0] mw_data_o,
  input logic             tlb_fill_o,
  input logic             tlb_wr_o,
  input logic             rsp_valid_o,
  input logic             rsp_ok_o,
  input logic [2:0]       rsp_fault_o
);
  assert_mw_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_valid_o && !mw_ack_i |=> mw_valid_o && $stable(mw_addr_o) && $stable(mw_data_o));

  // written-back entry always carries the accessed flag
  assert_mw_aset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_valid_o |-> mw_data_o[PB_A]);

  assert_tlb_upd_ok_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_fill_o || tlb_wr_o) |-> rsp_valid_o && rsp_ok_o);

  assert_fill_wr_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tlb_fill_o, tlb_wr_o}));

  assert_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_start_o || mw_valid_o) |-> !req_ready_o);

  assert_fault_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_ok_o == (rsp_fault_o == 3'd0)));
endmodule

bind xlat_ctrl xlat_ctrl_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .walk_start_o (walk_start_o),
  .mw_valid_o   (mw_valid_o),
  .mw_ack_i     (mw_ack_i),
  .mw_addr_o    (mw_addr_o),
  .mw_data_o    (mw_data_o),
  .tlb_fill_o   (tlb_fill_o),
  .tlb_wr_o     (tlb_wr_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ok_o     (rsp_ok_o),
  .rsp_fault_o  (rsp_fault_o)
);

// File: tb/xlat_ctrl_tb.sv
module xlat_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 39, PA_W = 56, ASID_W = 16, PPN_W = 44, PTE_W = 64, LVL_W = 2, IDX_W = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid_i = 1'b0, req_ready_o;
  logic [VA_W-1:0] req_vaddr_i = '0;
  logic [1:0] req_acc_i = '0;
  logic req_priv_s_i = 1'b0, req_mxr_i = 1'b0, req_sum_i = 1'b0;
  logic [ASID_W-1:0] asid_i = '0;
  logic [PPN_W-1:0] root_ppn_i = '0;
  logic paged_i = 1'b0, ad_upd_en_i = 1'b0;
  logic tlb_lkp_o; logic [VA_W-1:0] tlb_lkp_vaddr_o; logic [ASID_W-1:0] tlb_lkp_asid_o;
  logic tlb_hit_i; logic [IDX_W-1:0] tlb_hit_idx_i; logic [PTE_W-1:0] tlb_pte_i;
  logic [PA_W-1:0] tlb_pbase_i; logic [VA_W-1:0] tlb_sel_mask_i; logic [PA_W-1:0] tlb_pte_addr_i;
  logic tlb_fill_o, tlb_wr_o; logic [IDX_W-1:0] tlb_wr_idx_o;
  logic [VA_W-1:0] tlb_w_vaddr_o; logic [ASID_W-1:0] tlb_w_asid_o; logic [PA_W-1:0] tlb_w_paddr_o;
  logic [PTE_W-1:0] tlb_w_pte_o; logic [PA_W-1:0] tlb_w_pte_addr_o; logic [LVL_W-1:0] tlb_w_lvl_o;
  logic tlb_w_glb_o;
  logic walk_start_o; logic [VA_W-1:0] walk_vaddr_o; logic [PPN_W-1:0] walk_root_o;
  logic [1:0] walk_acc_o; logic walk_priv_s_o, walk_mxr_o, walk_sum_o;
  logic walk_done_i = 1'b0, walk_ok_i; logic [2:0] walk_err_i; logic [PA_W-1:0] walk_paddr_i;
  logic [PTE_W-1:0] walk_pte_i; logic [PA_W-1:0] walk_pte_addr_i; logic [LVL_W-1:0] walk_lvl_i;
  logic walk_glb_i;
  logic mw_valid_o; logic [PA_W-1:0] mw_addr_o; logic [PTE_W-1:0] mw_data_o;
  logic mw_ack_i = 1'b0, mw_err_i = 1'b0;
  logic rsp_valid_o, rsp_ok_o; logic [2:0] rsp_fault_o; logic [PA_W-1:0] rsp_paddr_o;

  // scenario configuration
  logic c_hit = 1'b0; logic [IDX_W-1:0] c_idx = '0; logic [PTE_W-1:0] c_pte = '0;
  logic [PA_W-1:0] c_base = '0, c_paddr_addr = '0; logic [VA_W-1:0] c_mask = '0;
  logic w_ok = 1'b1; logic [2:0] w_err = '0; logic [PA_W-1:0] w_pa = '0, w_addr = '0;
  logic [PTE_W-1:0] w_pte = '0; logic [LVL_W-1:0] w_lvl = '0; logic w_glb = 1'b0;
  logic c_mem_err = 1'b0;

  assign tlb_hit_i = c_hit;           assign tlb_hit_idx_i = c_idx;
  assign tlb_pte_i = c_pte;           assign tlb_pbase_i = c_base;
  assign tlb_sel_mask_i = c_mask;     assign tlb_pte_addr_i = c_paddr_addr;
  assign walk_ok_i = w_ok;            assign walk_err_i = w_err;
  assign walk_paddr_i = w_pa;         assign walk_pte_i = w_pte;
  assign walk_pte_addr_i = w_addr;    assign walk_lvl_i = w_lvl;
  assign walk_glb_i = w_glb;

  xlat_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .PPN_W(PPN_W), .PTE_W(PTE_W),
              .LVL_W(LVL_W), .IDX_W(IDX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i, .req_ready_o, .req_vaddr_i, .req_acc_i, .req_priv_s_i, .req_mxr_i, .req_sum_i,
    .asid_i, .root_ppn_i, .paged_i, .ad_upd_en_i,
    .tlb_lkp_o, .tlb_lkp_vaddr_o, .tlb_lkp_asid_o, .tlb_hit_i, .tlb_hit_idx_i, .tlb_pte_i,
    .tlb_pbase_i, .tlb_sel_mask_i, .tlb_pte_addr_i,
    .tlb_fill_o, .tlb_wr_o, .tlb_wr_idx_o, .tlb_w_vaddr_o, .tlb_w_asid_o, .tlb_w_paddr_o,
    .tlb_w_pte_o, .tlb_w_pte_addr_o, .tlb_w_lvl_o, .tlb_w_glb_o,
    .walk_start_o, .walk_vaddr_o, .walk_root_o, .walk_acc_o, .walk_priv_s_o, .walk_mxr_o,
    .walk_sum_o, .walk_done_i, .walk_ok_i, .walk_err_i, .walk_paddr_i, .walk_pte_i,
    .walk_pte_addr_i, .walk_lvl_i, .walk_glb_i,
    .mw_valid_o, .mw_addr_o, .mw_data_o, .mw_ack_i, .mw_err_i,
    .rsp_valid_o, .rsp_ok_o, .rsp_fault_o, .rsp_paddr_o
  );

  // monitor captures
  int n_chk = 0, n_bad = 0;
  int n_lkp, n_walk, n_mw, n_fill, n_wr, wcnt = 0, mcnt = 0;
  logic got_rsp, g_ok; logic [2:0] g_flt; logic [PA_W-1:0] g_pa;
  logic [PA_W-1:0] m_addr; logic [PTE_W-1:0] m_data;
  logic mw_prev_v = 1'b0, mw_unstable; logic [PA_W-1:0] mw_prev_a; logic [PTE_W-1:0] mw_prev_d;
  logic [255:0] f_cap; logic [IDX_W-1:0] wr_idx_cap; logic [PTE_W-1:0] wr_pte_cap;
  bit done = 0;

  always @(negedge clk) begin
    if (tlb_lkp_o) n_lkp++;
    // walker model: done two cycles after start
    if (walk_done_i) walk_done_i = 1'b0;
    else if (wcnt == 1) begin walk_done_i = 1'b1; wcnt = 0; end
    else if (wcnt > 1) wcnt--;
    if (walk_start_o) begin n_walk++; wcnt = 2; end
    // memory model
    if (mw_valid_o) begin
      if (mw_prev_v && (mw_addr_o != mw_prev_a || mw_data_o != mw_prev_d)) mw_unstable = 1'b1;
      mw_prev_v = 1'b1; mw_prev_a = mw_addr_o; mw_prev_d = mw_data_o;
    end else mw_prev_v = 1'b0;
    if (mw_ack_i) begin mw_ack_i = 1'b0; mw_err_i = 1'b0; end
    else if (mw_valid_o) begin
      mcnt++;
      if (mcnt == 2) begin
        mw_ack_i = 1'b1; mw_err_i = c_mem_err; n_mw++;
        m_addr = mw_addr_o; m_data = mw_data_o; mcnt = 0;
      end
    end
    if (tlb_fill_o) begin
      n_fill++;
      f_cap = {22'd0, tlb_w_vaddr_o, tlb_w_asid_o, tlb_w_paddr_o, tlb_w_pte_o,
               tlb_w_pte_addr_o, tlb_w_lvl_o, tlb_w_glb_o};
    end
    if (tlb_wr_o) begin n_wr++; wr_idx_cap = tlb_wr_idx_o; wr_pte_cap = tlb_w_pte_o; end
    if (rsp_valid_o) begin got_rsp = 1'b1; g_ok = rsp_ok_o; g_flt = rsp_fault_o; g_pa = rsp_paddr_o; end
  end

  task automatic chk(input bit cond, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic perm_f(logic [7:0] a, logic [1:0] acc, logic s, logic mxr, logic sum);
    logic ak, pk;
    ak = (acc == 2'd0) ? (a[1] | (a[3] & mxr)) : (acc == 2'd1) ? a[2] : (acc == 2'd2) ? a[3] : 1'b0;
    pk = s ? (!a[4] || (acc != 2'd2 && sum)) : a[4];
    return ak & pk;
  endfunction

  function automatic logic need_f(logic [PTE_W-1:0] p, logic st);
    return !p[6] || (st && !p[7]);
  endfunction

  function automatic logic [PTE_W-1:0] upd_f(logic [PTE_W-1:0] p, logic st);
    logic [PTE_W-1:0] r = p;
    r[6] = 1'b1;
    if (st) r[7] = 1'b1;
    return r;
  endfunction

  task automatic run(input logic [VA_W-1:0] va, input logic [1:0] acc, input logic s,
                     input logic mxr, input logic sum, input logic [ASID_W-1:0] asid,
                     input logic paged, input logic en);
    logic e_ok; logic [2:0] e_flt; logic [PA_W-1:0] e_pa; logic [PTE_W-1:0] e_mwd;
    logic [PA_W-1:0] e_mwa; logic e_walk, e_mw, e_fill, e_wr, st; string tag;
    n_lkp = 0; n_walk = 0; n_mw = 0; n_fill = 0; n_wr = 0; got_rsp = 1'b0; mw_unstable = 1'b0;
    req_vaddr_i = va; req_acc_i = acc; req_priv_s_i = s; req_mxr_i = mxr; req_sum_i = sum;
    asid_i = asid; paged_i = paged; ad_upd_en_i = en; root_ppn_i = {$urandom, $urandom};
    req_valid_i = 1'b1;
    @(posedge clk); #1 req_valid_i = 1'b0;
    if (paged) begin
      @(negedge clk); #1;
      chk(req_ready_o == 1'b0, "R10 busy", 256'(req_ready_o), 256'(0));
    end
    for (int i = 0; i < 40 && !got_rsp; i++) begin @(negedge clk); #1; end
    chk(got_rsp, "R10 response", 256'(got_rsp), 256'(1));
    @(negedge clk); #1;
    chk(rsp_valid_o == 1'b0, "R10 pulse", 256'(rsp_valid_o), 256'(0));

    st = (acc == 2'd1);
    e_ok = 1'b0; e_flt = 3'd0; e_pa = '0; e_walk = 0; e_mw = 0; e_fill = 0; e_wr = 0;
    e_mwd = '0; e_mwa = '0;
    if (!paged) begin
      tag = "R1"; e_ok = 1'b1; e_pa = {17'd0, va};
    end else if (c_hit) begin
      if (!perm_f(c_pte[7:0], acc, s, mxr, sum)) begin tag = "R2"; e_flt = 3'd3; end
      else if (need_f(c_pte, st)) begin
        if (!en) begin tag = "R5 hit"; e_flt = 3'd5; end
        else begin
          tag = "R6"; e_mw = 1; e_mwa = c_paddr_addr; e_mwd = upd_f(c_pte, st);
          if (c_mem_err) e_flt = 3'd1;
          else begin e_ok = 1'b1; e_wr = 1; e_pa = c_base | {17'd0, va & c_mask}; end
        end
      end else begin tag = "R3"; e_ok = 1'b1; e_pa = c_base | {17'd0, va & c_mask}; end
    end else begin
      e_walk = 1;
      if (!w_ok) begin tag = "R7"; e_flt = w_err; end
      else if (need_f(w_pte, st)) begin
        if (!en) begin tag = "R5 miss"; e_flt = 3'd5; end
        else begin
          tag = "R9"; e_mw = 1; e_mwa = w_addr; e_mwd = upd_f(w_pte, st);
          if (c_mem_err) e_flt = 3'd1;
          else begin e_ok = 1'b1; e_fill = 1; e_pa = w_pa; end
        end
      end else begin tag = "R8"; e_ok = 1'b1; e_fill = 1; e_pa = w_pa; end
    end

    chk(g_ok == e_ok && g_flt == e_flt && (!e_ok || g_pa == e_pa), tag,
        {g_ok, g_flt, g_pa}, {e_ok, e_flt, e_pa});
    chk(n_lkp == int'(paged) && n_walk == int'(e_walk) && n_mw == int'(e_mw) &&
        n_fill == int'(e_fill) && n_wr == int'(e_wr), {tag, " side effects"},
        {n_lkp[3:0], n_walk[3:0], n_mw[3:0], n_fill[3:0], n_wr[3:0]},
        {3'd0, paged, 3'd0, e_walk, 3'd0, e_mw, 3'd0, e_fill, 3'd0, e_wr});
    if (e_mw) begin
      chk(m_addr == e_mwa && m_data == e_mwd, {tag, " R4 write-back"}, {m_addr, m_data}, {e_mwa, e_mwd});
      chk(!mw_unstable, "R11", 256'(mw_unstable), 256'(0));
    end
    if (e_fill)
      chk(f_cap == {22'd0, va, asid, w_pa, e_mwd | (e_mw ? '0 : w_pte), w_addr, w_lvl, w_glb},
          {tag, " fill"}, f_cap, {22'd0, va, asid, w_pa, e_mw ? e_mwd : w_pte, w_addr, w_lvl, w_glb});
    if (e_wr)
      chk(wr_idx_cap == c_idx && wr_pte_cap == e_mwd, "R6 rewrite", {wr_idx_cap, wr_pte_cap}, {c_idx, e_mwd});
  endtask

  task automatic set_hit(input logic [7:0] attr, input int lvl);
    c_hit = 1'b1; c_idx = IDX_W'($urandom);
    c_pte = {$urandom, $urandom}; c_pte[7:0] = attr;
    c_mask = (VA_W'(1) << (12 + 9 * lvl)) - 1'b1;
    c_base = PA_W'({$urandom, $urandom}) & ~{17'd0, c_mask};
    c_paddr_addr = PA_W'({$urandom, $urandom}) & ~PA_W'(7);
  endtask

  task automatic set_walk(input logic ok, input logic [2:0] err, input logic [7:0] attr);
    c_hit = 1'b0; w_ok = ok; w_err = ok ? 3'd0 : err;
    w_pa = PA_W'({$urandom, $urandom}); w_pte = {$urandom, $urandom}; w_pte[7:0] = attr;
    w_addr = PA_W'({$urandom, $urandom}) & ~PA_W'(7);
    w_lvl = LVL_W'($urandom % 3); w_glb = 1'($urandom);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1; #1;
    chk(req_ready_o && !rsp_valid_o && !mw_valid_o && !tlb_fill_o && !tlb_wr_o && !walk_start_o,
        "R10 reset", {req_ready_o, rsp_valid_o, mw_valid_o, tlb_fill_o}, 256'h8);

    c_mem_err = 1'b0;
    run(39'h12_3456_789A, 2'd0, 1'b1, 0, 0, 16'h1, 1'b0, 1'b1);               // R1 bare
    set_hit(8'hD7, 0); run(39'h00_ABCD_E123, 2'd0, 1'b0, 0, 0, 16'h2, 1, 1);   // R3 user load
    set_hit(8'hD7, 2); run(39'h7F_FFFF_FFFF, 2'd1, 1'b0, 0, 0, 16'h2, 1, 1);   // R3 gigapage
    set_hit(8'hC7, 0); run(39'h00_0000_1000, 2'd0, 1'b0, 0, 0, 16'h2, 1, 1);   // R2 user, U clear
    set_hit(8'hD3, 0); run(39'h00_0000_2000, 2'd0, 1'b1, 0, 0, 16'h2, 1, 1);   // R2 sup on user page, no sum
    set_hit(8'hC9, 0); run(39'h00_0000_3000, 2'd0, 1'b1, 1, 0, 16'h2, 1, 1);   // R2 exec-only readable by mxr
    set_hit(8'h57, 1); run(39'h00_1234_5000, 2'd1, 1'b0, 0, 0, 16'h3, 1, 1);   // R4/R6 store, D clear
    set_hit(8'h57, 1); run(39'h00_1234_5000, 2'd1, 1'b0, 0, 0, 16'h3, 1, 0);   // R5 hit
    c_mem_err = 1'b1;
    set_hit(8'h17, 0); run(39'h00_2222_3000, 2'd0, 1'b0, 0, 0, 16'h3, 1, 1);   // R6 write error
    c_mem_err = 1'b0;
    set_walk(0, 3'd4, 8'hCF); run(39'h01_0000_0000, 2'd0, 1'b1, 0, 0, 16'h4, 1, 1); // R7
    set_walk(1, 3'd0, 8'hCF); run(39'h01_0000_1000, 2'd2, 1'b1, 0, 0, 16'h4, 1, 1); // R8
    set_walk(1, 3'd0, 8'h0F); run(39'h01_0000_2000, 2'd0, 1'b1, 0, 0, 16'h4, 1, 1); // R9
    set_walk(1, 3'd0, 8'h4F); run(39'h01_0000_3000, 2'd1, 1'b1, 0, 0, 16'h4, 1, 0); // R5 miss
    c_mem_err = 1'b1;
    set_walk(1, 3'd0, 8'h0F); run(39'h01_0000_4000, 2'd0, 1'b1, 0, 0, 16'h4, 1, 1); // R9 error

    for (int t = 0; t < 400; t++) begin
      c_mem_err = ($urandom % 8) == 0;
      if ($urandom % 2) set_hit(8'($urandom) | 8'h01, $urandom % 3);
      else set_walk(($urandom % 4) != 0, 3'(1 + $urandom % 4), 8'($urandom) | 8'h01);
      run(VA_W'({$urandom, $urandom}), 2'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom),
          ASID_W'($urandom), ($urandom % 8) != 0, ($urandom % 4) != 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule